// File: doc/BRIEF.md
# Time-of-Day Counter with BCD/Binary and 12/24-Hour Formats

This block holds the seconds, minutes and hours of a wall clock and advances them by one second each time an external one-second update strobe arrives. The strobe comes from a separate timebase block. Two mode inputs select how the fields are stored. One picks packed BCD or plain binary. The other picks the 12-hour or 24-hour format.

Software or a neighbouring block can load any single field through a byte-wide write port. All three fields are presented directly on output ports. A one-cycle day-carry pulse reports each transition into midnight, so that a downstream calendar block can advance the date. Date counting itself happens outside this block.

Top module: `tod_counter`

## Requirements
- R1: After reset, the seconds, minutes and hours outputs are 0x00 and the day-carry output is low.
- R2: With the write enable high, the select value 0 loads seconds, 1 loads minutes and 2 loads hours. The byte is visible on the field's output one clock later, stored exactly as written with no range correction.
- R3: A write with select value 3 changes no field.
- R4: A write cycle has priority over an update strobe in the same cycle. The written field takes the written byte, the strobe is discarded, and no other field moves.
- R5: Each strobe without a write advances seconds by one. Seconds wrap from 59 to 0 and then advance minutes. Minutes wrap from 59 to 0 and then advance hours. Without a strobe or a write, every field holds its value.
- R6: With the data-mode input low (BCD), a field whose low nibble is 9 or more steps to the next tens digit with the low nibble cleared, so 0x09 becomes 0x10. With the data-mode input high (binary), a field steps by plain +1, so 9 becomes 10 (0x0A).
- R7: With the 24-hour input high, hours count from 0 to 23 (0x23 in BCD, 23 in binary) and 23:59:59 steps to 00:00:00.
- R8: With the 24-hour input low, bit 7 of hours is the PM flag and bits 6:0 hold 1 to 12. Hour 11 steps to 12 with the PM flag inverted. Hour 12 steps to 1 with the flag unchanged. Midnight is 12 with PM clear (0x12 in BCD, 0x0C in binary).
- R9: The day-carry output is high for exactly the one cycle after the strobe that moves the clock into midnight. In 24-hour mode that is the step from 23:59:59. In 12-hour mode it is the step from 11:59:59 PM. It stays low for every other step.
- R10: A field holding an out-of-range value keeps counting from it. In BCD, 0x4A steps to 0x50. In binary, 70 steps to 71.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second update strobe, one cycle wide |
| binary_mode | input | 1 | 0 = packed BCD fields, 1 = binary fields |
| mode_24h | input | 1 | 0 = 12-hour with PM flag in bit 7, 1 = 24-hour |
| wr_en | input | 1 | Field write enable |
| wr_sel | input | 2 | Field select: 0 seconds, 1 minutes, 2 hours, 3 none |
| wr_data | input | 8 | Byte written to the selected field |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field (bit 7 = PM in 12-hour mode) |
| day_carry | output | 1 | One-cycle pulse on entry into midnight |

## Verification
The fields are the state itself, so a wrong carry decision shows up on an output port one clock after the strobe that caused it. Examples are a missed decimal carry, an inverted PM flag, or a minute that moves while the seconds have not wrapped. A faulty midnight detector is the only fault that can stay hidden for long, because it shows only as a missing or stray day-carry pulse at the single midnight step. The stimulus therefore forces each format and encoding to its wrap points directly through the write port, then checks the step and the pulse in the same cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int FIELD_W  = 8;
    localparam int SEL_W    = 2;
    localparam int MINSEC_LAST = 59;
    localparam int HOUR_LAST24 = 23;
    localparam int HALF_DAY    = 12;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC  = 2'd0,
        SEL_MIN  = 2'd1,
        SEL_HOUR = 2'd2,
        SEL_NONE = 2'd3
    } fsel_e;

    typedef struct packed {
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] hour;
        logic               carry;
    } tod_state_t;

    // Encode a small decimal count in the selected representation.
    function automatic logic [FIELD_W-1:0] enc(input int dec, input logic binary);
        logic [FIELD_W-1:0] r;
        if (binary) r = FIELD_W'(dec);
        else        r = FIELD_W'(((dec / 10) << 4) | (dec % 10));
        return r;
    endfunction

    // One-step increment: plain +1 or decimal nibble carry.
    function automatic logic [FIELD_W-1:0] step_code(input logic [FIELD_W-1:0] v,
                                                     input logic binary);
        logic [FIELD_W-1:0] r;
        if (binary)             r = v + 1'b1;
        else if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                    r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

endpackage

// File: rtl/tod_field_inc.sv
module tod_field_inc
    import tod_pkg::*;
#(
    parameter int LAST = MINSEC_LAST
) (
    input  logic [FIELD_W-1:0] cur,
    input  logic               binary,
    output logic [FIELD_W-1:0] nxt,
    output logic               wrap
);
    logic [FIELD_W-1:0] last_code;

    always_comb begin
        last_code = enc(LAST, binary);
        wrap      = (cur == last_code);
        nxt       = wrap ? '0 : step_code(cur, binary);
    end
endmodule

// File: rtl/tod_hour_inc.sv
module tod_hour_inc
    import tod_pkg::*;
(
    input  logic [FIELD_W-1:0] cur,
    input  logic               binary,
    input  logic               fmt24,
    output logic [FIELD_W-1:0] nxt,
    output logic               day_wrap
);
    logic               pm;
    logic [6:0]         h12;
    logic [6:0]         code12;
    logic [6:0]         code11;
    logic [FIELD_W-1:0] stepped;

    always_comb begin
        pm       = cur[FIELD_W-1];
        h12      = cur[6:0];
        code12   = 7'(enc(HALF_DAY, binary));
        code11   = 7'(enc(HALF_DAY - 1, binary));
        stepped  = step_code({1'b0, h12}, binary);
        nxt      = cur;
        day_wrap = 1'b0;
        if (fmt24) begin
            if (cur == enc(HOUR_LAST24, binary)) begin
                nxt      = '0;
                day_wrap = 1'b1;
            end else begin
                nxt = step_code(cur, binary);
            end
        end else begin
            if (h12 == code12) begin
                nxt = {pm, 7'd1};
            end else if (h12 == code11) begin
                nxt      = {~pm, code12};
                day_wrap = pm;
            end else begin
                nxt = {pm, stepped[6:0]};
            end
        end
    end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               binary_mode,
    input  logic               mode_24h,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [FIELD_W-1:0] sec_o,
    output logic [FIELD_W-1:0] min_o,
    output logic [FIELD_W-1:0] hour_o,
    output logic               day_carry
);
    localparam int NUM_LO = 2;

    tod_state_t st_d, st_q;

    logic [NUM_LO-1:0][FIELD_W-1:0] lo_cur;
    logic [NUM_LO-1:0][FIELD_W-1:0] lo_nxt;
    logic [NUM_LO-1:0]              lo_wrap;
    logic [FIELD_W-1:0]             hr_nxt;
    logic                           hr_wrap;

    assign lo_cur[0] = st_q.sec;
    assign lo_cur[1] = st_q.min;

    // Seconds and minutes share one sexagesimal stepper each.
    for (genvar g = 0; g < NUM_LO; g++) begin : g_lo
        tod_field_inc #(.LAST(MINSEC_LAST)) u_inc (
            .cur    (lo_cur[g]),
            .binary (binary_mode),
            .nxt    (lo_nxt[g]),
            .wrap   (lo_wrap[g])
        );
    end

    tod_hour_inc u_hour (
        .cur      (st_q.hour),
        .binary   (binary_mode),
        .fmt24    (mode_24h),
        .nxt      (hr_nxt),
        .day_wrap (hr_wrap)
    );

    always_comb begin
        st_d       = st_q;
        st_d.carry = 1'b0;
        if (wr_en) begin
            case (fsel_e'(wr_sel))
                SEL_SEC:  st_d.sec  = wr_data;
                SEL_MIN:  st_d.min  = wr_data;
                SEL_HOUR: st_d.hour = wr_data;
                default:  ;
            endcase
        end else if (tick) begin
            st_d.sec = lo_nxt[0];
            if (lo_wrap[0]) begin
                st_d.min = lo_nxt[1];
                if (lo_wrap[1]) begin
                    st_d.hour  = hr_nxt;
                    st_d.carry = hr_wrap;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_o     = st_q.sec;
    assign min_o     = st_q.min;
    assign hour_o    = st_q.hour;
    assign day_carry = st_q.carry;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
    import tod_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               binary_mode,
    input logic               wr_en,
    input logic [SEL_W-1:0]   wr_sel,
    input logic [FIELD_W-1:0] wr_data,
    input logic [FIELD_W-1:0] sec_o,
    input logic [FIELD_W-1:0] min_o,
    input logic [FIELD_W-1:0] hour_o,
    input logic               day_carry
);
    logic sec_at_last;
    assign sec_at_last = binary_mode ? (sec_o == 8'd59) : (sec_o == 8'h59);

    assert_sec_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> (sec_o == $past(wr_data)));

    assert_hour_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> (hour_o == $past(wr_data)));

    assert_null_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)));

    assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> ($stable(min_o) && $stable(hour_o)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && !day_carry));

    assert_tick_moves_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en) |=> (sec_o != $past(sec_o)));

    assert_min_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && !sec_at_last) |=> $stable(min_o));

    assert_carry_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry |=> !day_carry);

    assert_carry_at_midnight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry |-> (sec_o == 8'h00 && min_o == 8'h00));
endmodule

bind tod_counter tod_counter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .binary_mode (binary_mode),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .sec_o       (sec_o),
    .min_o       (min_o),
    .hour_o      (hour_o),
    .day_carry   (day_carry)
);

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
    localparam time HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       binary_mode = 1'b0;
    logic       mode_24h = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o;
    logic       day_carry;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        logic [7:0] s;
        logic [7:0] m;
        logic [7:0] h;
        logic       c;
        int         due;
        string      req;
    } exp_t;

    exp_t q[$];
    exp_t e;

    tod_counter u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .binary_mode(binary_mode),
        .mode_24h(mode_24h), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_carry(day_carry)
    );

    always #HALF clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares every expected item when its cycle is reached.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                e = q.pop_front();
                vectors++;
                if (sec_o !== e.s || min_o !== e.m || hour_o !== e.h || day_carry !== e.c) begin
                    miscompares++;
                    $display("FAIL %s: got h=%02h m=%02h s=%02h c=%0b, expected h=%02h m=%02h s=%02h c=%0b",
                             e.req, hour_o, min_o, sec_o, day_carry, e.h, e.m, e.s, e.c);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, optionally queueing the expected result.
    task automatic step(input bit t, input bit we, input logic [1:0] sel, input logic [7:0] d,
                        input bit chk, input logic [7:0] es, input logic [7:0] em,
                        input logic [7:0] eh, input bit ec, input string req);
        exp_t x;
        @(negedge clk);
        tick = t; wr_en = we; wr_sel = sel; wr_data = d;
        if (chk) begin
            x.s = es; x.m = em; x.h = eh; x.c = ec; x.due = cyc + 1; x.req = req;
            q.push_back(x);
        end
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        step(1'b0, 1'b1, sel, d, 1'b0, 8'h0, 8'h0, 8'h0, 1'b0, "");
    endtask

    task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(2'd2, h); wr(2'd1, m); wr(2'd0, s);
    endtask

    task automatic tick_chk(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input bit c, input string req);
        step(1'b1, 1'b0, 2'd0, 8'h00, 1'b1, s, m, h, c, req);
    endtask

    task automatic idle_chk(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input string req);
        step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, s, m, h, 1'b0, req);
    endtask

    task automatic summary();
        repeat (3) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 150000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_chk(8'h00, 8'h00, 8'h00, "R1 reset state");

        // 24-hour BCD
        binary_mode = 1'b0; mode_24h = 1'b1;
        wr(2'd2, 8'h09); wr(2'd1, 8'h59);
        step(1'b0, 1'b1, 2'd0, 8'h59, 1'b1, 8'h59, 8'h59, 8'h09, 1'b0, "R2 write seconds");
        tick_chk(8'h10, 8'h00, 8'h00, 1'b0, "R6 BCD hour 09 to 10");
        step(1'b1, 1'b1, 2'd0, 8'h30, 1'b1, 8'h30, 8'h00, 8'h10, 1'b0, "R4 write beats tick");
        step(1'b0, 1'b1, 2'd3, 8'h55, 1'b1, 8'h30, 8'h00, 8'h10, 1'b0, "R3 select 3 ignored");
        idle_chk(8'h10, 8'h00, 8'h30, "R5 hold without tick");
        set_hms(8'h05, 8'h10, 8'h59);
        tick_chk(8'h05, 8'h11, 8'h00, 1'b0, "R5 minute advance");
        set_hms(8'h00, 8'h00, 8'h00);
        for (int i = 0; i < 59; i++) tick_chk(8'h00, 8'h00, 8'(((i + 1) / 10) * 16 + (i + 1) % 10), 1'b0, "R5 seconds count");
        tick_chk(8'h00, 8'h01, 8'h00, 1'b0, "R5 sixty ticks make a minute");
        set_hms(8'h23, 8'h59, 8'h59);
        tick_chk(8'h00, 8'h00, 8'h00, 1'b1, "R7 R9 BCD midnight");
        idle_chk(8'h00, 8'h00, 8'h00, "R9 carry one cycle");

        // Out-of-range values
        step(1'b0, 1'b1, 2'd0, 8'h4A, 1'b1, 8'h4A, 8'h00, 8'h00, 1'b0, "R2 stored uncorrected");
        tick_chk(8'h00, 8'h00, 8'h50, 1'b0, "R10 BCD 4A to 50");

        // 24-hour binary
        binary_mode = 1'b1;
        set_hms(8'd23, 8'd59, 8'd59);
        tick_chk(8'h00, 8'h00, 8'h00, 1'b1, "R7 R9 binary midnight");
        set_hms(8'd9, 8'd59, 8'd59);
        tick_chk(8'h0A, 8'h00, 8'h00, 1'b0, "R6 binary 9 to 10");
        wr(2'd0, 8'd70);
        tick_chk(8'h0A, 8'h00, 8'd71, 1'b0, "R10 binary 70 to 71");

        // 12-hour BCD
        binary_mode = 1'b0; mode_24h = 1'b0;
        set_hms(8'h11, 8'h59, 8'h59);
        tick_chk(8'h92, 8'h00, 8'h00, 1'b0, "R8 BCD 11AM to 12PM");
        set_hms(8'h92, 8'h59, 8'h59);
        tick_chk(8'h81, 8'h00, 8'h00, 1'b0, "R8 BCD 12PM to 1PM");
        set_hms(8'h91, 8'h59, 8'h59);
        tick_chk(8'h12, 8'h00, 8'h00, 1'b1, "R8 R9 BCD 11PM to 12AM");
        set_hms(8'h12, 8'h59, 8'h59);
        tick_chk(8'h01, 8'h00, 8'h00, 1'b0, "R8 R9 BCD 12AM to 1AM");
        set_hms(8'h89, 8'h59, 8'h59);
        tick_chk(8'h90, 8'h00, 8'h00, 1'b0, "R8 R6 BCD 9PM to 10PM");

        // 12-hour binary
        binary_mode = 1'b1;
        set_hms(8'h0B, 8'd59, 8'd59);
        tick_chk(8'h8C, 8'h00, 8'h00, 1'b0, "R8 binary 11AM to 12PM");
        set_hms(8'h8C, 8'd59, 8'd59);
        tick_chk(8'h81, 8'h00, 8'h00, 1'b0, "R8 binary 12PM to 1PM");
        set_hms(8'h8B, 8'd59, 8'd59);
        tick_chk(8'h0C, 8'h00, 8'h00, 1'b1, "R8 R9 binary 11PM to 12AM");
        set_hms(8'h0C, 8'd59, 8'd59);
        tick_chk(8'h01, 8'h00, 8'h00, 1'b0, "R8 binary 12AM to 1AM");

        repeat (2) @(negedge clk);
        if (q.size() != 0) begin
            miscompares++;
            $display("FAIL R5 scoreboard: %0d items left, expected 0", q.size());
        end
        finished = 1;
        summary();
    end
endmodule